// File: doc/BRIEF.md
# Decoupled Prepare-To-Branch Unit

This block carries out control transfers that are split into three independent steps. A setup operation does one of two things. It can deposit a destination address into one of a small set of target registers. It can also evaluate a condition on two general-register values and store the one-bit outcome in one of a small set of predicate registers. A separate branch operation names a target register and a predicate register. It moves the program counter to that target only when the predicate holds. Where to go, whether to go and when to go are therefore decided by different operations, and each can be scheduled into an otherwise idle slot.

Each cycle the unit accepts at most one setup operation and one branch operation, on two strobed slots. Both slots issued in the same cycle form one bundle. The unit keeps the program counter. It reports the counter value and a flag saying that the last bundle redirected control. General-register operands arrive as input values; the register file itself lies outside the block.

Top module: `ptb_unit`

## Requirements
- R1: After a synchronous active-low reset, `pc` is 0 and `taken` is 0, every target register holds 0, and every predicate register except index 0 is false.
- R2: A setup with kind 0 writes `pc + sext(setup_off) * 4` into target register `setup_dst`, where `pc` is the value at issue and `setup_off` is an 8-bit signed word offset.
- R3: A setup with kind 1 writes the absolute address `setup_abs` into target register `setup_dst`.
- R4: A setup with kind 2 writes the general-register value `gpr_a` into target register `setup_dst`, for register-indirect transfers.
- R5: A setup with kind 3 writes a compare result into predicate register `setup_dst`. The result depends on `setup_cond`: 0 gives a==b, 1 gives a!=b, 2 gives signed a<b, 3 gives signed a>=b, with a=`gpr_a` and b=`gpr_b`.
- R6: A branch whose predicate register is true sets `pc` to the named target register's content on the next cycle, and `taken` is 1 for that cycle.
- R7: A bundle with no taken branch advances `pc` by 4 on the next cycle and leaves `taken` at 0.
- R8: Predicate register 0 always reads true, so a branch naming it is unconditional, and a compare that targets it has no effect.
- R9: When a setup and a branch issue in the same cycle, the branch uses the target and predicate values from before that setup's write.
- R10: A cycle with neither slot valid holds `pc` and drives `taken` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_valid | input | 1 | Setup slot strobe |
| setup_kind | input | 2 | 0 relative target, 1 absolute target, 2 register target, 3 compare |
| setup_dst | input | 3 | Target or predicate register index |
| setup_cond | input | 2 | Compare condition code |
| setup_off | input | 8 | Signed word offset for relative targets |
| setup_abs | input | 32 | Absolute target address |
| gpr_a | input | 32 | First general-register operand |
| gpr_b | input | 32 | Second general-register operand |
| br_valid | input | 1 | Branch slot strobe |
| br_tgt | input | 3 | Target register index used by the branch |
| br_pred | input | 3 | Predicate register index used by the branch |
| pc | output | 32 | Current program counter |
| taken | output | 1 | Last bundle redirected control |

## Verification
A corrupted target register stays hidden until a branch names it. From that edge on, `pc` shows the wrong address and every later relative target carries the error as well. A stuck or wrongly written predicate shows up on the first branch that uses it: `taken` flips, and `pc` is off by a whole target-minus-fall-through distance. The stimulus therefore follows every write with a branch that reads it back. It also reads registers it never wrote, to expose bad reset values, within one or two cycles.

// File: rtl/ptb_pkg.sv
// Shared encodings for the prepare-to-branch unit.
// Assumes: setup kinds and condition codes fit in two bits each.
package ptb_pkg;

    typedef enum logic [1:0] {
        SK_PREP_REL = 2'd0,
        SK_PREP_ABS = 2'd1,
        SK_PREP_REG = 2'd2,
        SK_COMPARE  = 2'd3
    } setup_kind_e;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_NE = 2'd1,
        CC_LT = 2'd2,
        CC_GE = 2'd3
    } cond_e;

endpackage

// File: rtl/ptb_target_file.sv
// Branch-target register file: one write port, one combinational read port.
// Assumes: N is a power of two; reads return the value before a same-edge write.
module ptb_target_file #(
    parameter int N     = 8,
    parameter int AW    = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [AW-1:0]    wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [AW-1:0]    rd_data
);

    logic [AW-1:0] slots [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [AW-1:0] q;

        // Hold one target address, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                q <= wr_data;
            end
        end

        assign slots[i] = q;
    end

    // Present the selected target.
    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/ptb_pred_file.sv
// Predicate register file of one-bit entries; entry 0 is hard-wired true.
// Assumes: N is a power of two; writes to entry 0 are dropped.
module ptb_pred_file #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_val
);

    logic [N-1:0] bits;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (i == 0) begin : g_const
            // Entry zero is constant true.
            assign bits[i] = 1'b1;
        end else begin : g_reg
            logic q;

            // Hold one predicate, false after reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (wr_en && wr_idx == IDX_W'(i)) begin
                    q <= wr_val;
                end
            end

            assign bits[i] = q;
        end
    end

    // Present the selected predicate.
    assign rd_val = bits[rd_idx];

endmodule

// File: rtl/ptb_cond_eval.sv
// Combinational condition evaluator for compare setups.
// Assumes: operands are two's complement for the ordered conditions.
module ptb_cond_eval
    import ptb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  cond_e         cond,
    output logic          result
);

    logic eq;
    logic lt;

    // Basic relations shared by all conditions.
    always_comb begin
        eq = (op_a == op_b);
        lt = ($signed(op_a) < $signed(op_b));
    end

    // Select the requested relation.
    always_comb begin
        unique case (cond)
            CC_EQ:   result = eq;
            CC_NE:   result = !eq;
            CC_LT:   result = lt;
            CC_GE:   result = !lt;
            default: result = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptb_pc_ctrl.sv
// Program counter and taken flag.
// Assumes: a bundle with any valid slot advances by one word unless redirected.
module ptb_pc_ctrl #(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc,
    output logic          taken
);

    localparam logic [AW-1:0] STEP = AW'(4);

    // Update the counter and the flag once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= RESET_PC;
            taken <= 1'b0;
        end else begin
            taken <= redirect;
            if (redirect) begin
                pc <= target;
            end else if (advance) begin
                pc <= pc + STEP;
            end
        end
    end

endmodule

// File: rtl/ptb_unit.sv
// Decoupled prepare-to-branch unit: setup slot fills target or predicate
// registers, branch slot redirects the counter when its predicate holds.
// Assumes: both slots may issue together; the branch reads pre-write state.
module ptb_unit
    import ptb_pkg::*;
#(
    parameter int            ADDR_W   = 32,
    parameter int            DATA_W   = 32,
    parameter int            N_REG    = 8,
    parameter int            OFF_W    = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    localparam int           IDX_W    = $clog2(N_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_valid,
    input  logic [1:0]        setup_kind,
    input  logic [IDX_W-1:0]  setup_dst,
    input  logic [1:0]        setup_cond,
    input  logic [OFF_W-1:0]  setup_off,
    input  logic [ADDR_W-1:0] setup_abs,
    input  logic [DATA_W-1:0] gpr_a,
    input  logic [DATA_W-1:0] gpr_b,
    input  logic              br_valid,
    input  logic [IDX_W-1:0]  br_tgt,
    input  logic [IDX_W-1:0]  br_pred,
    output logic [ADDR_W-1:0] pc,
    output logic              taken
);

    localparam int EXT_W = ADDR_W - OFF_W - 2;

    setup_kind_e       kind;
    logic              tgt_we;
    logic [ADDR_W-1:0] tgt_wdata;
    logic              pred_we;
    logic              cmp_res;
    logic [ADDR_W-1:0] tgt_rd;
    logic              pred_rd;
    logic [ADDR_W-1:0] rel_off;
    logic              redirect;
    logic              advance;

    // Decode the setup kind into register-file writes.
    always_comb begin
        kind    = setup_kind_e'(setup_kind);
        rel_off = {{EXT_W{setup_off[OFF_W-1]}}, setup_off, 2'b00};
        tgt_we  = setup_valid && (kind != SK_COMPARE);
        pred_we = setup_valid && (kind == SK_COMPARE);
        unique case (kind)
            SK_PREP_REL: tgt_wdata = pc + rel_off;
            SK_PREP_ABS: tgt_wdata = setup_abs;
            SK_PREP_REG: tgt_wdata = ADDR_W'(gpr_a);
            default:     tgt_wdata = '0;
        endcase
    end

    ptb_cond_eval #(
        .DW(DATA_W)
    ) u_cond (
        .op_a  (gpr_a),
        .op_b  (gpr_b),
        .cond  (cond_e'(setup_cond)),
        .result(cmp_res)
    );

    ptb_target_file #(
        .N (N_REG),
        .AW(ADDR_W)
    ) u_tgt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tgt_we),
        .wr_idx (setup_dst),
        .wr_data(tgt_wdata),
        .rd_idx (br_tgt),
        .rd_data(tgt_rd)
    );

    ptb_pred_file #(
        .N(N_REG)
    ) u_pred (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (pred_we),
        .wr_idx(setup_dst),
        .wr_val(cmp_res),
        .rd_idx(br_pred),
        .rd_val(pred_rd)
    );

    // Combine the branch decision and bundle activity.
    always_comb begin
        redirect = br_valid && pred_rd;
        advance  = setup_valid || br_valid;
    end

    ptb_pc_ctrl #(
        .AW      (ADDR_W),
        .RESET_PC(RESET_PC)
    ) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .redirect(redirect),
        .target  (tgt_rd),
        .pc      (pc),
        .taken   (taken)
    );

endmodule

// File: rtl/ptb_unit_chk.sv
// Property checker for ptb_unit, attached by bind.
// Assumes: observed signals follow the top module's port meanings.
module ptb_unit_chk #(
    parameter int            AW       = 32,
    parameter int            IDX_W    = 3,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             setup_valid,
    input logic             br_valid,
    input logic [IDX_W-1:0] br_pred,
    input logic             pred_rd,
    input logic [AW-1:0]    tgt_rd,
    input logic [AW-1:0]    pc,
    input logic             taken
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == RESET_PC) && !taken);

    // R6
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && pred_rd) |=> taken && (pc == $past(tgt_rd)));

    // R7
    sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((setup_valid || br_valid) && !(br_valid && pred_rd))
        |=> !taken && (pc == $past(pc) + AW'(4)));

    // R8
    pred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_pred == '0) |-> pred_rd);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!setup_valid && !br_valid) |=> !taken && $stable(pc));

endmodule

bind ptb_unit ptb_unit_chk #(
    .AW      (ADDR_W),
    .IDX_W   (IDX_W),
    .RESET_PC(RESET_PC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .setup_valid(setup_valid),
    .br_valid   (br_valid),
    .br_pred    (br_pred),
    .pred_rd    (pred_rd),
    .tgt_rd     (tgt_rd),
    .pc         (pc),
    .taken      (taken)
);

// File: tb/ptb_unit_test.sv
// Scoreboard bench for ptb_unit: the driver predicts, the monitor compares.
module ptb_unit_test;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0;
    logic [1:0]  setup_kind = '0;
    logic [2:0]  setup_dst = '0;
    logic [1:0]  setup_cond = '0;
    logic [7:0]  setup_off = '0;
    logic [31:0] setup_abs = '0;
    logic [31:0] gpr_a = '0;
    logic [31:0] gpr_b = '0;
    logic        br_valid = 1'b0;
    logic [2:0]  br_tgt = '0;
    logic [2:0]  br_pred = '0;
    logic [31:0] pc;
    logic        taken;

    typedef struct {
        logic [31:0] pc;
        logic        taken;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_errors = 0;
    logic [31:0] m_tgt [8];
    logic        m_pred [8];
    logic [31:0] m_pc;

    ptb_unit uut (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_kind(setup_kind),
        .setup_dst(setup_dst), .setup_cond(setup_cond),
        .setup_off(setup_off), .setup_abs(setup_abs),
        .gpr_a(gpr_a), .gpr_b(gpr_b),
        .br_valid(br_valid), .br_tgt(br_tgt), .br_pred(br_pred),
        .pc(pc), .taken(taken)
    );

    always #(CLK_P / 2) clk = ~clk;

    // Drive one bundle at the falling edge and push the predicted result.
    task automatic step(input logic sv, input logic [1:0] kind,
                        input logic [2:0] dst, input logic [1:0] cc,
                        input logic [7:0] off, input logic [31:0] abs_v,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic bv, input logic [2:0] bt,
                        input logic [2:0] bp, input string tag);
        logic  take;
        logic  res;
        exp_t  e;
        @(negedge clk);
        setup_valid = sv; setup_kind = kind; setup_dst = dst;
        setup_cond = cc; setup_off = off; setup_abs = abs_v;
        gpr_a = a; gpr_b = b; br_valid = bv; br_tgt = bt; br_pred = bp;
        take = bv && (bp == 3'd0 || m_pred[bp]);
        e.pc    = take ? m_tgt[bt] : ((sv || bv) ? m_pc + 32'd4 : m_pc);
        e.taken = take;
        e.tag   = tag;
        if (sv) begin
            case (kind)
                2'd0: m_tgt[dst] = m_pc + {{22{off[7]}}, off, 2'b00};
                2'd1: m_tgt[dst] = abs_v;
                2'd2: m_tgt[dst] = a;
                default: begin
                    case (cc)
                        2'd0: res = (a == b);
                        2'd1: res = (a != b);
                        2'd2: res = ($signed(a) < $signed(b));
                        default: res = ($signed(a) >= $signed(b));
                    endcase
                    if (dst != 3'd0) m_pred[dst] = res;
                end
            endcase
        end
        m_pc = e.pc;
        sb.push_back(e);
    endtask

    // Pop and compare one prediction after each rising edge.
    always @(posedge clk) begin
        #(CLK_P / 4);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (pc !== e.pc || taken !== e.taken) begin
                n_errors++;
                $display("FAIL %s: pc=%h taken=%b expected pc=%h taken=%b",
                         e.tag, pc, taken, e.pc, e.taken);
            end
        end
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        #(CLK_P * 100000);
        n_errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_tgt[i] = '0;
            m_pred[i] = (i == 0);
        end
        m_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_checks++;
        // R1 reset state at the ports
        if (pc !== 32'h0 || taken !== 1'b0) begin
            n_errors++;
            $display("FAIL R1 reset: pc=%h taken=%b expected pc=0 taken=0", pc, taken);
        end
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R10 idle hold");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 5, 0, "R1 reset target zero via R8");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 1, 3, "R1 reset predicate false, R7");
        step(1, 0, 1, 0, 8'h04, 0, 0, 0, 0, 0, 0, "R2 relative forward");
        step(1, 3, 3, 0, 8'h00, 0, 7, 7, 0, 0, 0, "R5 equal");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 1, 3, "R6 taken to relative target");
        step(1, 0, 2, 0, 8'hFD, 0, 0, 0, 0, 0, 0, "R2 relative backward");
        step(1, 3, 4, 1, 8'h00, 0, 5, 5, 0, 0, 0, "R5 not-equal false");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 2, 4, "R7 predicate false");
        step(1, 3, 4, 2, 8'h00, 0, 32'hFFFF_FFFF, 1, 0, 0, 0, "R5 signed less");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 2, 4, "R6 backward target");
        step(1, 1, 6, 0, 8'h00, 32'h1000, 0, 0, 0, 0, 0, "R3 absolute");
        step(1, 3, 5, 3, 8'h00, 0, 3, 32'hFFFF_FFFE, 0, 0, 0, "R5 signed ge");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 6, 5, "R3 branch to absolute");
        step(1, 2, 7, 0, 8'h00, 0, 32'h2468, 0, 0, 0, 0, "R4 register target");
        step(1, 3, 0, 0, 8'h00, 0, 1, 2, 0, 0, 0, "R8 write to zero dropped");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 7, 0, "R8 and R4 unconditional");
        step(1, 3, 5, 1, 8'h00, 0, 1, 1, 1, 6, 5, "R9 compare with branch");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 6, 5, "R9 predicate now false");
        step(1, 1, 6, 0, 8'h00, 32'h3000, 0, 0, 1, 6, 0, "R9 prepare with branch");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 6, 0, "R3 new absolute visible");
        step(1, 3, 2, 2, 8'h00, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, "R5 signed less false");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 6, 2, "R7 after false compare");
        step(0, 0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R10 idle after run");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule